// File: doc/BRIEF.md
# Closed-Loop Rail Margining Controller

This block trims supply rails through one PWM pin per rail. An external R-C network filters the pulse train into a DC level that is fed into the supply's feedback node. Each rail's measured voltage arrives as a digital sample. For every sample window the block compares that sample with the selected target and moves a saturating duty register by one LSB. The steps are rare on purpose, so that the supply's own regulation loop is not disturbed.

A rail is margined when a bus-written command asks for it, or when its enable and up/down pins do. The command wins whenever it is present. While margining, the target is the high or low margin voltage. Otherwise the rail follows an idle mode: output disabled, continuous trim toward the nominal target, or a fixed programmed duty.

Request and mode changes take effect only at a PWM period boundary. A fault-mask output lets the rail's fault detectors ignore events while a margin is applied.

Top module: `margin_ctrl`

## Requirements
- R1: A rail margins when its pin enable is high and no command is present. The up pin selects the margin-high target when high and the margin-low target when low.
- R2: While a rail's command-valid input is high, its command enable and command up bits replace the pin inputs completely.
- R3: While margining, each duty step moves toward the selected margin target, either the high or the low one.
- R4: With the polarity bit at 1, a sample below the target adds one LSB to the duty and a sample above it removes one. With the bit at 0, both directions are reversed.
- R5: A step is evaluated only on every N-th accepted sample, where N is step_div_i and a value of 0 acts as 1. The sample counter clears whenever the rail is not adjusting.
- R6: When the absolute difference between the sample and the target is at most deadband_i, the duty does not change.
- R7: The duty saturates at 0 and at 2^DW-1 and never wraps.
- R8: The PWM period is 2^DW clocks. The output is high while the shared counter is below the effective duty, which is also shown on duty_o.
- R9: The idle mode codes are 0 for output disabled (oe and pwm low), 1 for trim toward nominal, and 2 for fixed duty taken from fixed_duty_i. Code 3 behaves like 0.
- R10: Changes to the margin request and the idle mode take effect on the first clock of the next PWM period, when the counter is 0.
- R11: fault_mask_o is high only while the rail is margining and its ignore-faults bit is set.
- R12: After reset the duty is 0, no rail is margining, all outputs are disabled and the period counter starts at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_valid_i | input | NCH | Per-rail strobe marking a new voltage sample |
| vmeas_i | input | NCH*VW | Per-rail measured rail voltage |
| tgt_hi_i | input | NCH*VW | Per-rail margin-high target |
| tgt_lo_i | input | NCH*VW | Per-rail margin-low target |
| tgt_nom_i | input | NCH*VW | Per-rail nominal target |
| deadband_i | input | VW | Error band in which the duty is held |
| step_div_i | input | DIVW | Samples per duty step (0 acts as 1) |
| polarity_i | input | NCH | 1 means a higher duty raises the rail |
| idle_mode_i | input | 2*NCH | Per-rail idle mode code |
| fixed_duty_i | input | NCH*DW | Per-rail duty for fixed idle mode |
| fault_ign_i | input | NCH | Per-rail option to ignore faults while margining |
| cmd_valid_i | input | NCH | Bus command present for the rail |
| cmd_en_i | input | NCH | Command margin enable |
| cmd_up_i | input | NCH | Command margin direction, 1 = high |
| pin_en_i | input | NCH | Pin margin enable |
| pin_up_i | input | NCH | Pin margin direction, 1 = high |
| pwm_o | output | NCH | PWM drive per rail |
| pwm_oe_o | output | NCH | Output enable per rail |
| duty_o | output | NCH*DW | Effective duty per rail |
| fault_mask_o | output | NCH | Fault-ignore indication per rail |

## Verification
The integrator is driven with samples below, above and inside the deadband, under both polarity settings, and with step divisors of 1 and 3. These runs separate a wrong step direction, a band edge that is off by one, and a divisor that counts samples wrongly. Long one-sided runs drive the duty into both rails, which exposes any wrap-around.

A full sweep of fixed duties counts the high clocks in each period, to catch an off-by-one in the comparator. Mode, pin and command requests are changed in the middle of a period and observed clock by clock. This shows whether a change takes effect early, whether the command outranks the pins, and which target each direction selects.

// File: rtl/margin_pkg.sv
package margin_pkg;
  typedef enum logic [1:0] {
    IDLE_HIZ   = 2'd0,
    IDLE_TRIM  = 2'd1,
    IDLE_FIXED = 2'd2,
    IDLE_RSVD  = 2'd3
  } idle_mode_e;
endpackage

// File: rtl/margin_pwm_timer.sv
module margin_pwm_timer #(
  parameter int DW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [DW-1:0] cnt_o,
  output logic          wrap_o
);
  localparam logic [DW-1:0] CNT_LAST = {DW{1'b1}};

  logic [DW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = (cnt_q == CNT_LAST);
endmodule

// File: rtl/margin_mode_sel.sv
module margin_mode_sel
  import margin_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wrap_i,
  input  logic       cmd_valid_i,
  input  logic       cmd_en_i,
  input  logic       cmd_up_i,
  input  logic       pin_en_i,
  input  logic       pin_up_i,
  input  logic [1:0] idle_mode_i,
  output logic       act_o,
  output logic       up_o,
  output idle_mode_e mode_o
);
  logic       act_q, up_q;
  idle_mode_e mode_q;
  logic       req_en, req_up;

  // bus command outranks pins
  assign req_en = cmd_valid_i ? cmd_en_i : pin_en_i;
  assign req_up = cmd_valid_i ? cmd_up_i : pin_up_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      up_q   <= 1'b0;
      mode_q <= IDLE_HIZ;
    end else if (wrap_i) begin
      act_q  <= req_en;
      up_q   <= req_up;
      mode_q <= idle_mode_e'(idle_mode_i);
    end
  end

  assign act_o  = act_q;
  assign up_o   = up_q;
  assign mode_o = mode_q;

  // R10
  boundary_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wrap_i |=> ($stable(act_q) && $stable(up_q) && $stable(mode_q)));
endmodule

// File: rtl/margin_integ.sv
module margin_integ #(
  parameter int DW   = 12,
  parameter int VW   = 12,
  parameter int DIVW = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            adj_en_i,
  input  logic            sv_i,
  input  logic [VW-1:0]   vmeas_i,
  input  logic [VW-1:0]   target_i,
  input  logic [VW-1:0]   deadband_i,
  input  logic [DIVW-1:0] step_div_i,
  input  logic            pol_i,
  output logic [DW-1:0]   duty_o
);
  localparam logic [DW-1:0] DUTY_MAX = {DW{1'b1}};

  logic [DW-1:0]   duty_q;
  logic [DIVW-1:0] scnt_q, div_last;
  logic            below, outside, raise_req, lower_req, step_up, step_dn;
  logic [VW-1:0]   err_mag;

  assign div_last  = (step_div_i == '0) ? '0 : step_div_i - 1'b1;
  assign below     = vmeas_i < target_i;
  assign err_mag   = below ? (target_i - vmeas_i) : (vmeas_i - target_i);
  assign outside   = err_mag > deadband_i;
  assign raise_req = outside && below;
  assign lower_req = outside && !below;
  assign step_up   = pol_i ? raise_req : lower_req;
  assign step_dn   = pol_i ? lower_req : raise_req;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      duty_q <= '0;
      scnt_q <= '0;
    end else if (!adj_en_i) begin
      scnt_q <= '0;
    end else if (sv_i) begin
      if (scnt_q >= div_last) begin
        scnt_q <= '0;
        if (step_up && duty_q != DUTY_MAX)  duty_q <= duty_q + 1'b1;
        else if (step_dn && duty_q != '0)   duty_q <= duty_q - 1'b1;
      end else begin
        scnt_q <= scnt_q + 1'b1;
      end
    end
  end

  assign duty_o = duty_q;

  // R5
  step_on_sample_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sv_i |=> $stable(duty_q));
  // R7
  no_wrap_up_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (duty_q == DUTY_MAX) |=> (duty_q != '0));
  // R7
  no_wrap_dn_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (duty_q == '0) |=> (duty_q != DUTY_MAX));
endmodule

// File: rtl/margin_ctrl.sv
module margin_ctrl
  import margin_pkg::*;
#(
  parameter int NCH  = 4,
  parameter int DW   = 12,
  parameter int VW   = 12,
  parameter int DIVW = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NCH-1:0]    sample_valid_i,
  input  logic [NCH*VW-1:0] vmeas_i,
  input  logic [NCH*VW-1:0] tgt_hi_i,
  input  logic [NCH*VW-1:0] tgt_lo_i,
  input  logic [NCH*VW-1:0] tgt_nom_i,
  input  logic [VW-1:0]     deadband_i,
  input  logic [DIVW-1:0]   step_div_i,
  input  logic [NCH-1:0]    polarity_i,
  input  logic [2*NCH-1:0]  idle_mode_i,
  input  logic [NCH*DW-1:0] fixed_duty_i,
  input  logic [NCH-1:0]    fault_ign_i,
  input  logic [NCH-1:0]    cmd_valid_i,
  input  logic [NCH-1:0]    cmd_en_i,
  input  logic [NCH-1:0]    cmd_up_i,
  input  logic [NCH-1:0]    pin_en_i,
  input  logic [NCH-1:0]    pin_up_i,
  output logic [NCH-1:0]    pwm_o,
  output logic [NCH-1:0]    pwm_oe_o,
  output logic [NCH*DW-1:0] duty_o,
  output logic [NCH-1:0]    fault_mask_o
);
  logic [DW-1:0] cnt;
  logic          wrap;

  margin_pwm_timer #(.DW(DW)) i_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cnt_o  (cnt),
    .wrap_o (wrap)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_rail
    logic          act, up, adj_en;
    idle_mode_e    mode;
    logic [VW-1:0] target;
    logic [DW-1:0] duty_int, duty_eff;

    margin_mode_sel i_sel (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .wrap_i      (wrap),
      .cmd_valid_i (cmd_valid_i[g]),
      .cmd_en_i    (cmd_en_i[g]),
      .cmd_up_i    (cmd_up_i[g]),
      .pin_en_i    (pin_en_i[g]),
      .pin_up_i    (pin_up_i[g]),
      .idle_mode_i (idle_mode_i[2*g +: 2]),
      .act_o       (act),
      .up_o        (up),
      .mode_o      (mode)
    );

    assign target = act ? (up ? tgt_hi_i[g*VW +: VW] : tgt_lo_i[g*VW +: VW])
                        : tgt_nom_i[g*VW +: VW];
    assign adj_en = act || (mode == IDLE_TRIM);

    margin_integ #(.DW(DW), .VW(VW), .DIVW(DIVW)) i_integ (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .adj_en_i   (adj_en),
      .sv_i       (sample_valid_i[g]),
      .vmeas_i    (vmeas_i[g*VW +: VW]),
      .target_i   (target),
      .deadband_i (deadband_i),
      .step_div_i (step_div_i),
      .pol_i      (polarity_i[g]),
      .duty_o     (duty_int)
    );

    assign duty_eff = (!act && mode == IDLE_FIXED) ? fixed_duty_i[g*DW +: DW] : duty_int;
    assign duty_o[g*DW +: DW] = duty_eff;
    assign pwm_oe_o[g]     = act || (mode == IDLE_TRIM) || (mode == IDLE_FIXED);
    assign pwm_o[g]        = pwm_oe_o[g] && (cnt < duty_eff);
    assign fault_mask_o[g] = act && fault_ign_i[g];

    // R11
    mask_needs_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fault_mask_o[g] |-> pwm_oe_o[g]);
  end
endmodule

// File: tb/test_margin_ctrl.sv
module test_margin_ctrl;
  localparam int NCH = 2, DW = 6, VW = 8, DIVW = 4;
  localparam int PER = 1 << DW;

  logic              clk = 0, rst_ni = 0;
  logic [NCH-1:0]    sv = '0;
  logic [NCH*VW-1:0] vmeas = '0, thi = '0, tlo = '0, tnom = '0;
  logic [VW-1:0]     db = '0;
  logic [DIVW-1:0]   sdiv = '0;
  logic [NCH-1:0]    pol = '0, fign = '0, cv = '0, ce = '0, cu = '0, pe = '0, pu = '0;
  logic [2*NCH-1:0]  mode = '0;
  logic [NCH*DW-1:0] fduty = '0;
  logic [NCH-1:0]    pwm, oe, fmask;
  logic [NCH*DW-1:0] duty;

  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  margin_ctrl #(.NCH(NCH), .DW(DW), .VW(VW), .DIVW(DIVW)) i_margin_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .sample_valid_i(sv), .vmeas_i(vmeas),
    .tgt_hi_i(thi), .tgt_lo_i(tlo), .tgt_nom_i(tnom), .deadband_i(db),
    .step_div_i(sdiv), .polarity_i(pol), .idle_mode_i(mode),
    .fixed_duty_i(fduty), .fault_ign_i(fign), .cmd_valid_i(cv),
    .cmd_en_i(ce), .cmd_up_i(cu), .pin_en_i(pe), .pin_up_i(pu),
    .pwm_o(pwm), .pwm_oe_o(oe), .duty_o(duty), .fault_mask_o(fmask)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // rail 1 runs fixed duty 1: pwm_o[1] high only while counter is 0
  task automatic sync();
    @(negedge clk);
    while (!pwm[1]) @(negedge clk);
  endtask

  task automatic sample(int v);
    vmeas[VW-1:0] = VW'(v);
    sv[0] = 1'b1;
    @(negedge clk);
    sv[0] = 1'b0;
  endtask

  task automatic step_chk(string req, int v, int exp);
    sample(v);
    check(req, int'(duty[DW-1:0]), exp);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int d, hi;
    repeat (3) @(negedge clk);
    // R12 reset state
    check("R12 duty", int'(duty[DW-1:0]), 0);
    check("R12 oe", int'(oe), 0);
    check("R12 mask", int'(fmask), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R12 counter at 0", int'(pwm[0]), 0);

    mode[3:2] = 2'd2; fduty[2*DW-1:DW] = 1;
    mode[1:0] = 2'd1; tnom[VW-1:0] = 100; pol[0] = 1; sdiv = 3;
    sync();
    // R5 divide by 3, R9 trim toward nominal
    step_chk("R5 first", 50, 0);
    step_chk("R5 second", 50, 0);
    step_chk("R5 third", 50, 1);
    sdiv = 0;
    step_chk("R5 zero acts as 1", 50, 2);
    sdiv = 1;
    step_chk("R9 trim up", 50, 3);
    step_chk("R9 trim up", 50, 4);
    // R4 polarity
    pol[0] = 0;
    step_chk("R4 reversed", 50, 3);
    step_chk("R4 reversed above", 150, 4);
    pol[0] = 1;
    step_chk("R4 above lowers", 150, 3);
    // R6 deadband
    db = 5;
    step_chk("R6 in band low", 95, 3);
    step_chk("R6 out band low", 94, 4);
    step_chk("R6 in band high", 105, 4);
    step_chk("R6 out band high", 106, 3);
    step_chk("R6 exact", 100, 3);
    db = 0;
    // R7 saturation both ends
    d = 3;
    for (int i = 0; i < 70; i++) begin
      d = (d < PER - 1) ? d + 1 : d;
      step_chk("R7 sat high", 50, d);
    end
    pol[0] = 0;
    for (int i = 0; i < 70; i++) begin
      d = (d > 0) ? d - 1 : d;
      step_chk("R7 sat low", 50, d);
    end
    pol[0] = 1;

    // R8 fixed duty sweep
    mode[1:0] = 2'd2;
    for (int k = 0; k < PER; k++) begin
      sync();
      fduty[DW-1:0] = DW'(k);
      hi = 0;
      for (int c = 0; c < PER; c++) begin
        @(negedge clk);
        hi += int'(pwm[0]);
        if (!oe[0]) hi = -1000;
      end
      check("R8 high clocks", hi, k);
      check("R8 duty_o", int'(duty[DW-1:0]), k);
    end

    // R9 disabled modes 0 and 3
    for (int m = 0; m < 4; m += 3) begin
      mode[1:0] = 2'(m);
      sync();
      hi = 0;
      for (int c = 0; c < PER; c++) begin
        @(negedge clk);
        hi += int'(pwm[0]) + int'(oe[0]);
      end
      check("R9 output off", hi, 0);
    end

    // R10 pin request mid-period, R1 pins, R11 mask
    thi[VW-1:0] = 150; tlo[VW-1:0] = 40; fign[0] = 1;
    sync();
    repeat (5) @(negedge clk);
    pe[0] = 1; pu[0] = 1;
    hi = 0;
    while (!pwm[1]) begin
      hi += int'(fmask[0]);
      @(negedge clk);
    end
    check("R10 no early change", hi, 0);
    check("R10 at boundary", int'(fmask[0]), 1);
    check("R1 pin margin oe", int'(oe[0]), 1);
    // R3 high target
    step_chk("R3 up below hi", 140, 1);
    step_chk("R3 up below hi", 140, 2);
    step_chk("R3 up above hi", 160, 1);
    pu[0] = 0;
    sync();
    step_chk("R3 down above lo", 50, 0);
    step_chk("R3 down below lo", 30, 1);
    fign[0] = 0;
    #1;
    check("R11 option off", int'(fmask[0]), 0);
    fign[0] = 1;

    // R2 command priority
    cv[0] = 1; ce[0] = 0;
    sync();
    check("R2 cmd off beats pin", int'(fmask[0]), 0);
    check("R2 idle hiz", int'(oe[0]), 0);
    ce[0] = 1; cu[0] = 1;
    sync();
    step_chk("R2 cmd up beats pin down", 100, 2);
    cv[0] = 0;
    sync();
    step_chk("R1 back to pin down", 100, 1);
    pe[0] = 0;
    sync();
    check("R1 pin released", int'(fmask[0]), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule